// File: doc/BRIEF.md
# Cooperative Group Leader Arbiter

This block coordinates a small group of compact genetic algorithm cells that work on the same problem in parallel. Each neighbouring cell sends a one-cycle report strobe whenever its confidence counter has advanced. With the strobe it presents the counter value and its full probability vector. The leader holds each report until it has used it. Among the neighbours with a report waiting, it adopts the vector of the one with the highest confidence. It then drives that vector onto a shared broadcast bus with a one-cycle load strobe, so every normal cell in the group can reload it.

Each probability entry is a fraction of 256 and runs from 0 to 256. The adopted vector has converged once every entry sits at one of the two extremes. At that point the leader raises a sticky done flag, and the broadcast vector is the final solution. After that the leader takes no further reports. The sampling and fitness logic inside the cells is not part of this block.

Top module: `cga_group_leader`

## Requirements
- R1: After reset, `bcast_load` and `done` are low, and every entry of `bcast_vec` holds the initial probability 128.
- R2: A report strobe on `nbr_valid[i]` in clock cycle k, while `done` is low, makes `bcast_load` high for exactly cycle k+2. In that cycle `bcast_vec` carries the vector that neighbour i presented with the strobe. `bcast_load` is never high earlier than that.
- R3: When several neighbours have reports waiting in the same cycle, the leader adopts the vector of the neighbour with the largest confidence value on `nbr_conf`. Neighbour i's confidence is `nbr_conf[i*16 +: 16]`.
- R4: When the largest confidence values are equal, the lower-numbered neighbour wins.
- R5: In a cycle with no waiting report, `bcast_load` stays low and `bcast_vec` does not change.
- R6: A report that arrives in the same cycle that an earlier report is consumed is kept. It produces its own broadcast one cycle after the earlier one.
- R7: `done` rises in the same cycle as the `bcast_load` whose vector has every entry equal to 0 or 256. It stays high until reset. Entry j of a vector occupies bits `[j*9 +: 9]`, and neighbour i's vector occupies `nbr_vec[i*288 +: 288]`.
- R8: While `done` is high, report strobes are ignored: `bcast_load` stays low and `bcast_vec` keeps the final solution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| nbr_valid | input | 2 | One report strobe per neighbour |
| nbr_conf | input | 32 | Confidence values, 16 bits per neighbour |
| nbr_vec | input | 576 | Probability vectors, 32 entries of 9 bits per neighbour |
| bcast_vec | output | 288 | Adopted vector broadcast to the cells |
| bcast_load | output | 1 | One-cycle load strobe for `bcast_vec` |
| done | output | 1 | Adopted vector has converged; sticky |

## Verification
The bench sends two reports with equal confidence. A design that compared with greater-or-equal would pick neighbour 1 and broadcast the wrong vector. It also sends a report in the very cycle the previous one is being cleared. A leader that let the clear win would drop the second broadcast entirely. Convergence is checked with a vector mixing 0 and 256 entries. A detector testing only one extreme, or testing the wrong width, would miss `done` or raise it early. Strobes after `done` look for a leader that keeps broadcasting and so overwrites the final solution.

// File: rtl/cgl_pkg.sv
package cgl_pkg;
  localparam int PROB_W_DEF = 9;
  localparam int CONF_W_DEF = 16;
  localparam int VEC_LEN_DEF = 32;
  localparam int NBR_DEF = 2;

  // an entry is settled when it sits at either end of the probability range
  function automatic logic entry_at_rail(input logic [PROB_W_DEF-1:0] p);
    return (p == '0) || (p == PROB_W_DEF'(256));
  endfunction
endpackage

// File: rtl/cgl_nbr_slot.sv
module cgl_nbr_slot #(
  parameter int CONF_W = 16,
  parameter int VEC_W  = 288
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic              accept_en,
  input  logic              consume,
  input  logic [CONF_W-1:0] conf_in,
  input  logic [VEC_W-1:0]  vec_in,
  output logic              pend,
  output logic [CONF_W-1:0] conf_q,
  output logic [VEC_W-1:0]  vec_q
);
  logic capture;
  assign capture = strobe & accept_en;

  // a fresh report beats the clear of an older one
  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
    end else if (capture) begin
      pend <= 1'b1;
    end else if (consume) begin
      pend <= 1'b0;
    end
  end

  // payload registers carry no reset so they map onto plain fabric flops
  always_ff @(posedge clk) begin
    if (capture) begin
      conf_q <= conf_in;
      vec_q  <= vec_in;
    end
  end
endmodule

// File: rtl/cgl_argmax.sv
module cgl_argmax #(
  parameter int NBR    = 2,
  parameter int CONF_W = 16,
  localparam int IDX_W = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic [NBR-1:0]        pend,
  input  logic [NBR*CONF_W-1:0] conf_flat,
  output logic                  any,
  output logic [IDX_W-1:0]      win_idx
);
  always_comb begin
    logic [CONF_W-1:0] best;
    any     = 1'b0;
    win_idx = '0;
    best    = '0;
    for (int i = 0; i < NBR; i++) begin
      // strict compare keeps the lower index on a tie
      if (pend[i] && (!any || (conf_flat[i*CONF_W +: CONF_W] > best))) begin
        any     = 1'b1;
        win_idx = IDX_W'(i);
        best    = conf_flat[i*CONF_W +: CONF_W];
      end
    end
  end
endmodule

// File: rtl/cgl_settle_chk.sv
module cgl_settle_chk
  import cgl_pkg::*;
#(
  parameter int VEC_LEN = 32,
  parameter int PROB_W  = 9,
  localparam int VEC_W  = VEC_LEN * PROB_W
) (
  input  logic [VEC_W-1:0] vec,
  output logic             settled
);
  logic [VEC_LEN-1:0] at_rail;

  for (genvar j = 0; j < VEC_LEN; j++) begin : g_entry
    assign at_rail[j] = (vec[j*PROB_W +: PROB_W] == '0) ||
                        (vec[j*PROB_W +: PROB_W] == PROB_W'(256));
  end

  assign settled = &at_rail;
endmodule

// File: rtl/cga_group_leader.sv
module cga_group_leader
  import cgl_pkg::*;
#(
  parameter int NBR       = NBR_DEF,
  parameter int CONF_W    = CONF_W_DEF,
  parameter int VEC_LEN   = VEC_LEN_DEF,
  parameter int PROB_W    = PROB_W_DEF,
  parameter int INIT_PROB = 128,
  localparam int VEC_W    = VEC_LEN * PROB_W,
  localparam int IDX_W    = (NBR > 1) ? $clog2(NBR) : 1
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NBR-1:0]        nbr_valid,
  input  logic [NBR*CONF_W-1:0] nbr_conf,
  input  logic [NBR*VEC_W-1:0]  nbr_vec,
  output logic [VEC_W-1:0]      bcast_vec,
  output logic                  bcast_load,
  output logic                  done
);
  localparam logic [VEC_W-1:0] INIT_VEC = {VEC_LEN{PROB_W'(INIT_PROB)}};

  logic [NBR-1:0]        pend;
  logic [NBR*CONF_W-1:0] conf_held;
  logic [VEC_W-1:0]      vec_held [NBR];
  logic                  any_pend;
  logic [IDX_W-1:0]      win_idx;
  logic [VEC_W-1:0]      win_vec;
  logic                  win_settled;
  logic                  take;

  assign take = any_pend & ~done;

  for (genvar i = 0; i < NBR; i++) begin : g_slot
    cgl_nbr_slot #(
      .CONF_W(CONF_W),
      .VEC_W (VEC_W)
    ) u_slot (
      .clk      (clk),
      .rst      (rst),
      .strobe   (nbr_valid[i]),
      .accept_en(~done),
      .consume  (take),
      .conf_in  (nbr_conf[i*CONF_W +: CONF_W]),
      .vec_in   (nbr_vec[i*VEC_W +: VEC_W]),
      .pend     (pend[i]),
      .conf_q   (conf_held[i*CONF_W +: CONF_W]),
      .vec_q    (vec_held[i])
    );
  end

  cgl_argmax #(
    .NBR   (NBR),
    .CONF_W(CONF_W)
  ) u_argmax (
    .pend     (pend),
    .conf_flat(conf_held),
    .any      (any_pend),
    .win_idx  (win_idx)
  );

  assign win_vec = vec_held[win_idx];

  cgl_settle_chk #(
    .VEC_LEN(VEC_LEN),
    .PROB_W (PROB_W)
  ) u_settle (
    .vec    (win_vec),
    .settled(win_settled)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      bcast_vec  <= INIT_VEC;
      bcast_load <= 1'b0;
      done       <= 1'b0;
    end else begin
      bcast_load <= take;
      if (take) begin
        bcast_vec <= win_vec;
        if (win_settled) begin
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/cgl_leader_chk.sv
module cgl_leader_chk #(
  parameter int NBR     = 2,
  parameter int VEC_LEN = 32,
  parameter int PROB_W  = 9,
  localparam int VEC_W  = VEC_LEN * PROB_W
) (
  input logic             clk,
  input logic             rst,
  input logic [NBR-1:0]   nbr_valid,
  input logic [VEC_W-1:0] bcast_vec,
  input logic             bcast_load,
  input logic             done
);
  logic [VEC_LEN-1:0] rail_ok;
  for (genvar j = 0; j < VEC_LEN; j++) begin : g_rail
    assign rail_ok[j] = (bcast_vec[j*PROB_W +: PROB_W] == '0) ||
                        (bcast_vec[j*PROB_W +: PROB_W] == PROB_W'(256));
  end

  AST_LOAD_NEEDS_REPORT: assert property (@(posedge clk) disable iff (rst)
    bcast_load |-> $past(|nbr_valid, 2)); // R2
  AST_QUIET_VEC_STABLE: assert property (@(posedge clk) disable iff (rst)
    !bcast_load |-> $stable(bcast_vec)); // R5
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (rst)
    done |=> done); // R7
  AST_DONE_WITH_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> bcast_load); // R7
  AST_DONE_VEC_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
    done |-> (&rail_ok)); // R7
  AST_NO_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (rst)
    done |=> !bcast_load); // R8
endmodule

bind cga_group_leader cgl_leader_chk #(
  .NBR    (NBR),
  .VEC_LEN(VEC_LEN),
  .PROB_W (PROB_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .nbr_valid (nbr_valid),
  .bcast_vec (bcast_vec),
  .bcast_load(bcast_load),
  .done      (done)
);

// File: tb/sim_cga_group_leader.sv
`timescale 1ns/1ps
module sim_cga_group_leader;
  localparam int NBR = 2;
  localparam int CW  = 16;
  localparam int LEN = 32;
  localparam int PW  = 9;
  localparam int VW  = LEN * PW;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [NBR-1:0]    nbr_valid = '0;
  logic [NBR*CW-1:0] nbr_conf = '0;
  logic [NBR*VW-1:0] nbr_vec = '0;
  logic [VW-1:0]     bcast_vec;
  logic              bcast_load;
  logic              done;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  cga_group_leader u0 (
    .clk       (clk),
    .rst       (rst),
    .nbr_valid (nbr_valid),
    .nbr_conf  (nbr_conf),
    .nbr_vec   (nbr_vec),
    .bcast_vec (bcast_vec),
    .bcast_load(bcast_load),
    .done      (done)
  );

  function automatic logic [VW-1:0] mk_vec(input int seed);
    logic [VW-1:0] v;
    for (int j = 0; j < LEN; j++) v[j*PW +: PW] = PW'(((seed * 7 + j * 13) % 255) + 1);
    return v;
  endfunction

  function automatic logic [VW-1:0] mk_rail_vec();
    logic [VW-1:0] v;
    for (int j = 0; j < LEN; j++) v[j*PW +: PW] = (j % 3 == 0) ? PW'(256) : PW'(0);
    return v;
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk_bit(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic chk_vec(input string req, input logic [VW-1:0] act, input logic [VW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put(input int i, input int conf, input logic [VW-1:0] v);
    nbr_valid[i]        = 1'b1;
    nbr_conf[i*CW +: CW] = CW'(conf);
    nbr_vec[i*VW +: VW]  = v;
  endtask

  task automatic t_reset();
    chk_bit("R1 load", bcast_load, 1'b0);
    chk_bit("R1 done", done, 1'b0);
    chk_vec("R1 vec", bcast_vec, {LEN{PW'(128)}});
  endtask

  task automatic t_single();
    put(1, 5, mk_vec(1));
    step();
    nbr_valid = '0;
    chk_bit("R2 not early", bcast_load, 1'b0);
    step();
    chk_bit("R2 load", bcast_load, 1'b1);
    chk_vec("R2 vec", bcast_vec, mk_vec(1));
    step();
    chk_bit("R2 one cycle", bcast_load, 1'b0);
  endtask

  task automatic t_max();
    put(0, 3, mk_vec(2));
    put(1, 9, mk_vec(3));
    step();
    nbr_valid = '0;
    step();
    chk_bit("R3 load", bcast_load, 1'b1);
    chk_vec("R3 highest conf", bcast_vec, mk_vec(3));
    step();
    chk_bit("R3 single load", bcast_load, 1'b0);
  endtask

  task automatic t_tie();
    put(0, 7, mk_vec(4));
    put(1, 7, mk_vec(5));
    step();
    nbr_valid = '0;
    step();
    chk_bit("R4 load", bcast_load, 1'b1);
    chk_vec("R4 tie lower index", bcast_vec, mk_vec(4));
    step();
  endtask

  task automatic t_idle();
    logic [VW-1:0] held;
    held = bcast_vec;
    for (int c = 0; c < 5; c++) begin
      step();
      chk_bit("R5 no load", bcast_load, 1'b0);
      chk_vec("R5 vec held", bcast_vec, held);
    end
  endtask

  task automatic t_back_to_back();
    put(0, 1, mk_vec(6));
    step();
    nbr_valid = '0;
    put(1, 0, mk_vec(7));
    step();
    nbr_valid = '0;
    chk_bit("R6 first load", bcast_load, 1'b1);
    chk_vec("R6 first vec", bcast_vec, mk_vec(6));
    step();
    chk_bit("R6 second load", bcast_load, 1'b1);
    chk_vec("R6 second vec", bcast_vec, mk_vec(7));
    step();
    chk_bit("R6 end", bcast_load, 1'b0);
  endtask

  task automatic t_converge();
    put(0, 4, mk_rail_vec());
    put(1, 2, mk_vec(8));
    step();
    nbr_valid = '0;
    chk_bit("R7 not early", done, 1'b0);
    step();
    chk_bit("R7 load", bcast_load, 1'b1);
    chk_bit("R7 done", done, 1'b1);
    chk_vec("R7 final vec", bcast_vec, mk_rail_vec());
    step();
    chk_bit("R7 sticky", done, 1'b1);
  endtask

  task automatic t_after_done();
    put(0, 50, mk_vec(9));
    put(1, 60, mk_vec(10));
    step();
    nbr_valid = '0;
    for (int c = 0; c < 4; c++) begin
      step();
      chk_bit("R8 no load", bcast_load, 1'b0);
      chk_vec("R8 vec kept", bcast_vec, mk_rail_vec());
      chk_bit("R8 done", done, 1'b1);
    end
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    t_reset();
    t_single();
    t_max();
    t_tie();
    t_idle();
    t_back_to_back();
    t_converge();
    t_after_done();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule